// File: doc/BRIEF.md
# Flash Command and Status Unit

This unit sits between a processor's write port and an embedded flash array. Command bytes arrive as single writes. The unit decodes them and starts program and block-erase operations on an external sequencer. It keeps an 8-bit status byte that holds a ready flag and two error flags, and it decides whether a read of the array returns stored data or that status byte.

Writes enter through a valid/ready handshake. A write is taken on any clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low during reset and high at all other times, so the unit never applies back-pressure. A command that is refused is still consumed; it simply has no effect. The three flags are also driven to a separate control view, `ctl_view`. The sequencer reports the end of an operation with a one-cycle `op_done` pulse, and with `op_fail` when the operation failed.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset, `ctl_view` is 3'b001 (ready, no errors), reads return array data, and `wr_ready` is high from the first clock edge after reset is released.
- R2: The status byte has ready (1 = ready, 0 = busy) on bit 7, the erase-error flag on bit 5 and the program-error flag on bit 4. Bits 6 and 3..0 read 0.
- R3: `ctl_view` bit 0 is ready, bit 1 is program-error and bit 2 is erase-error. These bits always equal the matching status byte bits.
- R4: A write of 0x40 followed by a second write starts a program. `op_start` pulses for one cycle, with `op_erase`=0 and the second write's address and data. Ready reads 0 from that same cycle.
- R5: A write of 0x20 followed by a write of 0xD0 starts an erase, with `op_erase`=1 and the confirm write's address. If the second write is any other byte, no operation starts and reads return to array data.
- R6: On the edge where `op_done` is seen while busy, ready returns to 1. If `op_fail` is high on that edge, the error flag of the running operation's kind is set on the same edge.
- R7: A write of 0x50 while ready and no command is pending clears both error flags.
- R8: While either error flag is 1, the bytes 0x40 and 0x20 are ignored. No operation starts, the read mode is unchanged, and the next write is decoded as a new command.
- R9: A write of 0x70, and every start of a program or erase, makes reads return the status byte. A write of 0xFF, or of any byte that is not a command, makes reads return array data.
- R10: While busy, every write except 0x70 is ignored. This includes 0xFF, 0x50, 0x40 and 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | ADDR_W | Write address (used by the second write of a program or erase) |
| wr_data | input | 8 | Write data or command byte |
| arr_rdata | input | 8 | Data read from the flash array |
| rd_data | output | 8 | Read result: array data or the status byte |
| ctl_view | output | 3 | Flag mirror: {erase error, program error, ready} |
| op_start | output | 1 | One-cycle pulse that starts an operation |
| op_erase | output | 1 | Kind of operation: 1 = erase, 0 = program |
| op_addr | output | ADDR_W | Target address of the operation |
| op_wdata | output | 8 | Program data (0xD0 for an erase) |
| op_done | input | 1 | Operation finished, one-cycle pulse |
| op_fail | input | 1 | Operation failed, valid together with op_done |

## Verification
The assertions assume that the sequencer pulses `op_done` only while the unit is busy, that each pulse lasts one cycle, and that `op_fail` is meaningful only together with `op_done`. The bench sequencer stub follows these rules. It arms a countdown only when it sees `op_start`, and it raises `op_done` exactly once per operation, so the ready edge and the error update always fall inside a busy window. The stimulus leaves at least one idle cycle between writes. Arbitrary command bytes are also written while the unit is busy, because R10 defines how those bytes must be handled.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_RD_STATUS = 8'h70;
  localparam logic [BYTE_W-1:0] CMD_CLR_ERR   = 8'h50;
  localparam logic [BYTE_W-1:0] CMD_PROGRAM   = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_ERASE     = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_ERASE_OK  = 8'hD0;

  // bit positions inside the status byte
  localparam int SB_READY = 7;
  localparam int SB_EERR  = 5;
  localparam int SB_PERR  = 4;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_PROG  = 2'd1,
    PEND_ERASE = 2'd2
  } pend_e;

  typedef struct packed {
    logic eerr;
    logic perr;
    logic ready;
  } flags_t;
endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [BYTE_W-1:0] cmd,
  input  logic              busy,
  input  logic              err_any,
  output logic              start_prog,
  output logic              start_erase,
  output logic              clr_err,
  output logic              to_status,
  output logic              to_array,
  output logic              idle
);
  pend_e pend_q, pend_d;

  always_comb begin
    pend_d      = pend_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    clr_err     = 1'b0;
    to_status   = 1'b0;
    to_array    = 1'b0;
    if (wr_fire) begin
      if (busy) begin
        if (cmd == CMD_RD_STATUS) to_status = 1'b1;
      end else begin
        unique case (pend_q)
          PEND_PROG: begin
            start_prog = 1'b1;
            pend_d     = PEND_NONE;
          end
          PEND_ERASE: begin
            if (cmd == CMD_ERASE_OK) start_erase = 1'b1;
            else                     to_array    = 1'b1;
            pend_d = PEND_NONE;
          end
          default: begin
            unique case (cmd)
              CMD_RD_ARRAY:  to_array  = 1'b1;
              CMD_RD_STATUS: to_status = 1'b1;
              CMD_CLR_ERR:   clr_err   = 1'b1;
              CMD_PROGRAM:   if (!err_any) pend_d = PEND_PROG;
              CMD_ERASE:     if (!err_any) pend_d = PEND_ERASE;
              default:       to_array  = 1'b1;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= PEND_NONE;
    else        pend_q <= pend_d;
  end

  assign idle = (pend_q == PEND_NONE);
endmodule

// File: rtl/fcs_status_reg.sv
module fcs_status_reg
  import flash_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   kind_erase,
  input  logic   done,
  input  logic   fail,
  input  logic   clr_err,
  output flags_t flags
);
  logic busy_q, perr_q, eerr_q;
  logic finish;

  assign finish = busy_q && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else begin
      if (start)       busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      if (clr_err) begin
        perr_q <= 1'b0;
        eerr_q <= 1'b0;
      end else if (finish && fail) begin
        if (kind_erase) eerr_q <= 1'b1;
        else            perr_q <= 1'b1;
      end
    end
  end

  assign flags.ready = ~busy_q;
  assign flags.perr  = perr_q;
  assign flags.eerr  = eerr_q;
endmodule

// File: rtl/fcs_read_path.sv
module fcs_read_path
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              to_status,
  input  logic              to_array,
  input  flags_t            flags,
  input  logic [BYTE_W-1:0] arr_rdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              is_status
);
  logic              mode_q;
  logic [BYTE_W-1:0] status_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= 1'b0;
    else if (to_status) mode_q <= 1'b1;
    else if (to_array)  mode_q <= 1'b0;
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_sb
    if (b == SB_READY) begin : g_rdy
      assign status_byte[b] = flags.ready;
    end else if (b == SB_EERR) begin : g_ee
      assign status_byte[b] = flags.eerr;
    end else if (b == SB_PERR) begin : g_pe
      assign status_byte[b] = flags.perr;
    end else begin : g_rsv
      assign status_byte[b] = 1'b0;
    end
  end

  assign is_status = mode_q;
  assign rd_data   = mode_q ? status_byte : arr_rdata;
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] arr_rdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic [2:0]        ctl_view,
  output logic              op_start,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_wdata,
  input  logic              op_done,
  input  logic              op_fail
);
  logic   wr_fire, start_prog, start_erase, start_any;
  logic   clr_err, to_status, to_array, cmd_idle, rd_is_status;
  logic   rdy_q;
  flags_t flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign wr_ready  = rdy_q;
  assign wr_fire   = wr_valid && rdy_q;
  assign start_any = start_prog || start_erase;

  fcs_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .cmd        (wr_data),
    .busy       (~flags.ready),
    .err_any    (flags.perr | flags.eerr),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .clr_err    (clr_err),
    .to_status  (to_status),
    .to_array   (to_array),
    .idle       (cmd_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_start <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      op_start <= start_any;
      if (start_any) begin
        op_erase <= start_erase;
        op_addr  <= wr_addr;
        op_wdata <= wr_data;
      end
    end
  end

  fcs_status_reg u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_any),
    .kind_erase(op_erase),
    .done      (op_done),
    .fail      (op_fail),
    .clr_err   (clr_err),
    .flags     (flags)
  );

  fcs_read_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .to_status(to_status | start_any),
    .to_array (to_array),
    .flags    (flags),
    .arr_rdata(arr_rdata),
    .rd_data  (rd_data),
    .is_status(rd_is_status)
  );

  assign ctl_view = {flags.eerr, flags.perr, flags.ready};
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [2:0] ctl_view,
  input logic       op_start,
  input logic       op_done,
  input logic       op_fail,
  input logic       rd_is_status,
  input logic       cmd_idle
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_status |-> (rd_data & 8'h4F) == 8'h00);

  p_view_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_status |-> (rd_data[7] == ctl_view[0] && rd_data[5] == ctl_view[2]
                      && rd_data[4] == ctl_view[1]));

  p_busy_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (!ctl_view[0] && rd_is_status && !rd_data[7]));

  p_ready_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_view[0] && op_done) |=> ctl_view[0]);

  p_fail_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_view[0] && op_done && op_fail) |=> (ctl_view[2:1] != 2'b00));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && ctl_view[0] && cmd_idle && wr_data == 8'h50)
      |=> ctl_view[2:1] == 2'b00);

  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_view[2:1] != 2'b00) |=> !op_start);

  p_array_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && ctl_view[0] && cmd_idle && wr_data == 8'hFF)
      |=> !rd_is_status);

  p_busy_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_view[0] && wr_valid && wr_ready) |=> !op_start);
endmodule

bind flash_cmd_status fcs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .ctl_view    (ctl_view),
  .op_start    (op_start),
  .op_done     (op_done),
  .op_fail     (op_fail),
  .rd_is_status(rd_is_status),
  .cmd_idle    (cmd_idle)
);

// File: tb/flash_cmd_status_test.sv
module flash_cmd_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int OP_LAT     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        arr_rdata = 8'h00;
  logic [7:0]        rd_data;
  logic [2:0]        ctl_view;
  logic              op_start, op_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_wdata;
  logic              op_done = 1'b0;
  logic              op_fail = 1'b0;

  int    checks = 0;
  int    errors = 0;
  bit    chk_en = 1'b0;
  bit    fail_plan = 1'b0;
  bit    finished = 1'b0;
  string phase = "R1";
  int    cnt = 0;
  int    cyc = 0;

  flash_cmd_status #(.ADDR_W(ADDR_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit              m_ready, m_perr, m_eerr, m_stat, m_start, m_wrdy, m_kind;
  int              m_pend;
  logic [ADDR_W-1:0] m_addr;
  logic [7:0]      m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 1; m_perr = 0; m_eerr = 0; m_stat = 0; m_pend = 0;
      m_start = 0; m_wrdy = 0; m_kind = 0; m_addr = '0; m_data = '0;
    end else begin
      bit old_ready, go;
      old_ready = m_ready;
      go = 0;
      if (!old_ready && op_done) begin
        m_ready = 1;
        if (op_fail) begin
          if (m_kind) m_eerr = 1; else m_perr = 1;
        end
      end
      if (wr_valid && m_wrdy) begin
        if (!old_ready) begin
          if (wr_data == 8'h70) m_stat = 1;
        end else if (m_pend == 1) begin
          go = 1; m_kind = 0; m_pend = 0;
        end else if (m_pend == 2) begin
          if (wr_data == 8'hD0) begin go = 1; m_kind = 1; end
          else m_stat = 0;
          m_pend = 0;
        end else begin
          case (wr_data)
            8'hFF: m_stat = 0;
            8'h70: m_stat = 1;
            8'h50: begin m_perr = 0; m_eerr = 0; end
            8'h40: if (!(m_perr || m_eerr)) m_pend = 1;
            8'h20: if (!(m_perr || m_eerr)) m_pend = 2;
            default: m_stat = 0;
          endcase
        end
      end
      if (go) begin
        m_ready = 0; m_stat = 1; m_addr = wr_addr; m_data = wr_data;
      end
      m_start = go;
      m_wrdy  = 1;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (chk_en) begin
      logic [7:0] exp_rd;
      exp_rd = m_stat ? {m_ready, 1'b0, m_eerr, m_perr, 4'b0000} : arr_rdata;
      check("rd_data", 32'(rd_data), 32'(exp_rd));
      check("ctl_view", 32'(ctl_view), 32'({m_eerr, m_perr, m_ready}));
      check("wr_ready", 32'(wr_ready), 32'(m_wrdy));
      check("op_start", 32'(op_start), 32'(m_start));
      if (m_start) begin
        check("op_erase", 32'(op_erase), 32'(m_kind));
        check("op_addr", 32'(op_addr), 32'(m_addr));
        check("op_wdata", 32'(op_wdata), 32'(m_data));
      end
    end
  end

  // sequencer stub
  always @(negedge clk) begin
    if (op_done) begin
      op_done = 0; op_fail = 0;
    end
    if (rst_n && op_start) cnt = OP_LAT;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin op_done = 1; op_fail = fail_plan; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    #1 arr_rdata = 8'(cyc * 37 + 5);
  end

  task automatic wr(input logic [7:0] d, input logic [ADDR_W-1:0] a = '0);
    @(posedge clk); #1;
    wr_valid = 1; wr_data = d; wr_addr = a;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ctl_view[0] && cnt == 0 && !op_done) break;
    end
    idle(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3); #1 rst_n = 1;
    chk_en = 1;
    phase = "R1"; idle(3);                        // R1 reset values
    phase = "R2"; wr(8'h70); idle(2);              // R2 status byte 0x80
    phase = "R9"; wr(8'hFF); idle(2);              // R9 back to array
    phase = "R4"; wr(8'h40); wr(8'h5A, 16'h1234);  // R4 program
    wait_ready();
    phase = "R6"; fail_plan = 1;                   // R6 program failure
    wr(8'h40); wr(8'h11, 16'h0042); wait_ready(); fail_plan = 0;
    phase = "R3"; idle(2);                         // R3 mirror with error set
    phase = "R8"; wr(8'h40); wr(8'h12); idle(2);   // R8 program refused
    wr(8'h70); wr(8'h20); wr(8'hD0, 16'h0800); idle(OP_LAT + 2); // R8 erase refused
    phase = "R7"; wr(8'h50); idle(2);              // R7 clear
    phase = "R5"; wr(8'h20); wr(8'hD0, 16'h4000); wait_ready(); // R5 erase
    wr(8'h20); wr(8'h33, 16'h4000); idle(OP_LAT + 2);           // R5 bad confirm
    phase = "R6"; fail_plan = 1;                   // R6 erase failure
    wr(8'h20); wr(8'hD0, 16'h2000); wait_ready(); fail_plan = 0;
    wr(8'h50);
    phase = "R10"; wr(8'h40); wr(8'hC3, 16'h00AA); // R10 commands while busy
    wr(8'hFF); wr(8'h50); wr(8'h40); wr(8'h70);
    wait_ready();
    wr(8'hFF); wr(8'h40); wr(8'h7E, 16'h0001);
    wr(8'h20); wr(8'hD0); wait_ready();
    phase = "R9"; wr(8'h33); idle(2);              // R9 unknown byte
    wr(8'h70); idle(1); wr(8'h99); idle(2);
    chk_en = 0;
    finish_run();
  end
endmodule